// File: doc/BRIEF.md
# Instruction Fetch Parity Checker

This block guards the data array of an instruction cache with byte parity. Each time a cache line fill writes a 64-bit fetch unit, the block computes one even-parity bit for each of its eight bytes and stores those bits next to the data. Every later fetch reads the unit back and recomputes the parity. A mismatch in any of the eight bytes marks the whole unit as bad.

The error is never corrected. It travels with the first instruction of the unit, which is the 32-bit slot at the lowest address. The pipeline carries that tag forward and presents it again at execute. If the tagged instruction actually executes, the block raises a one-cycle prefetch abort. It also loads a fault address register with the unit-aligned address and a fault status register with the parity code. A tagged instruction that is killed before execute leaves no trace.

A test-only injection input can flip a chosen stored parity bit during a fill, so that the error path can be driven on purpose.

Top module: `ifetch_parity_guard`

## Requirements
- R1: A fill writes `fill_data` into entry `fill_idx`. A later fetch whose address bits [6:3] select that entry returns the same 64 bits on `rd_data` with `rd_fault` all zero, provided no injection was applied.
- R2: Parity is written only by a fill. Refilling an entry without injection replaces stored bad parity, and the next fetch of that entry reports no fault.
- R3: With `inj_en` high during a fill, the stored parity bit of byte `inj_byte` is inverted. Byte k is `fill_data[8k+7:8k]`. A fetch of that entry then reports a fault, for each of the eight byte positions.
- R4: A faulting unit sets only `rd_fault[0]`, the flag of the instruction at the lowest address. All other bits of `rd_fault` stay zero.
- R5: `rd_valid` is high exactly in the cycle after a cycle with `fetch_en` high. `rd_addr` is then `fetch_addr` with its low three bits forced to zero.
- R6: When `ex_valid` is high, `ex_kill` low and `ex_fault` high at a clock edge, `pabort` is high for the following cycle only. In that cycle `ifar` equals `{ex_unit, 3'b000}` and `ifsr` equals the parity code 5'h1A.
- R7: When an execute slot is killed, does not carry a fault, or is not valid, `pabort` stays low and `ifar` and `ifsr` keep their values.
- R8: After reset, `pabort` and `rd_valid` are low, and `ifar` and `ifsr` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one fetch unit from a line fill |
| fill_idx | input | IDX_W (4) | Entry written by the fill |
| fill_data | input | 64 | Fill data for the unit |
| inj_en | input | 1 | Test only: invert one stored parity bit on this fill |
| inj_byte | input | 3 | Byte whose parity bit is inverted |
| fetch_en | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W (12) | Byte address of the fetch |
| rd_valid | output | 1 | Fetch result valid |
| rd_addr | output | ADDR_W (12) | Unit-aligned address of the result |
| rd_data | output | 64 | Fetched unit |
| rd_fault | output | SLOTS (2) | Per-instruction parity fault tag |
| ex_valid | input | 1 | Instruction present at execute |
| ex_kill | input | 1 | Instruction at execute is flushed |
| ex_fault | input | 1 | Parity tag carried by the instruction |
| ex_unit | input | ADDR_W-3 (9) | Fetch unit address carried by the instruction |
| pabort | output | 1 | Prefetch abort pulse |
| ifar | output | ADDR_W (12) | Instruction fault address register |
| ifsr | output | FSR_W (5) | Instruction fault status register |

## Verification
The assertions assume that the execute-side inputs `ex_valid`, `ex_kill`, `ex_fault` and `ex_unit` are settled at each clock edge. They also assume that no fill writes the same entry in the cycle that entry is fetched, because a read returns the old contents on a collision. The stimulus changes every input on the falling edge and keeps fills and fetches in separate cycles. It therefore never produces a same-edge race or a read/write collision. The only parity errors it creates come through the injection input, so every expected fault is known from the sweep position.

// File: rtl/ifpg_pkg.sv
package ifpg_pkg;
   localparam int UNIT_BYTES = 8;
   localparam int UNIT_W     = UNIT_BYTES * 8;
   localparam int OFS_W      = $clog2(UNIT_BYTES);
   localparam int BSEL_W     = $clog2(UNIT_BYTES);

   typedef logic [UNIT_BYTES-1:0] par_vec_t;

   function automatic logic byte_even_par(input logic [7:0] b);
      return ^b;
   endfunction
endpackage

// File: rtl/ifpg_par_gen.sv
module ifpg_par_gen
   import ifpg_pkg::*;
#(
   parameter int NBYTES = UNIT_BYTES
) (
   input  logic [NBYTES*8-1:0] data,
   output logic [NBYTES-1:0]   par
);
   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      assign par[k] = byte_even_par(data[8*k +: 8]);
   end
endmodule

// File: rtl/ifpg_store.sv
module ifpg_store
   import ifpg_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 12,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [UNIT_W-1:0] wr_data,
   input  par_vec_t          wr_par,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [UNIT_W-1:0] rd_data,
   output par_vec_t          rd_par
);
   logic [UNIT_W-1:0] data_mem [DEPTH];
   par_vec_t          par_mem  [DEPTH];
   logic [IDX_W-1:0]  rd_idx;

   assign rd_idx = rd_addr_i[IDX_W+OFS_W-1:OFS_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            data_mem[k] <= '0;
            par_mem[k]  <= '0;
         end
      end else if (wr_en) begin
         data_mem[wr_idx] <= wr_data;
         par_mem[wr_idx]  <= wr_par;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_addr_o <= '0;
         rd_data   <= '0;
         rd_par    <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_addr_o <= {rd_addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            rd_data   <= data_mem[rd_idx];
            rd_par    <= par_mem[rd_idx];
         end
      end
   end
endmodule

// File: rtl/ifpg_check.sv
module ifpg_check
   import ifpg_pkg::*;
#(
   parameter int SLOTS = 2
) (
   input  logic              valid,
   input  logic [UNIT_W-1:0] data,
   input  par_vec_t          par_stored,
   output logic [SLOTS-1:0]  fault
);
   par_vec_t par_calc;
   logic     unit_bad;

   ifpg_par_gen #(.NBYTES(UNIT_BYTES)) u_regen (
      .data (data),
      .par  (par_calc)
   );

   assign unit_bad = |(par_calc ^ par_stored);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s == 0) begin : g_first
         assign fault[s] = valid & unit_bad;
      end else begin : g_rest
         assign fault[s] = 1'b0;
      end
   end
endmodule

// File: rtl/ifpg_fault_cap.sv
module ifpg_fault_cap
   import ifpg_pkg::*;
#(
   parameter int              ADDR_W     = 12,
   parameter int              FSR_W      = 5,
   parameter logic [FSR_W-1:0] FSR_PARITY = 5'h1A
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ex_valid,
   input  logic                    ex_kill,
   input  logic                    ex_fault,
   input  logic [ADDR_W-OFS_W-1:0] ex_unit,
   output logic                    pabort,
   output logic [ADDR_W-1:0]       ifar,
   output logic [FSR_W-1:0]        ifsr
);
   logic take;

   assign take = ex_valid & ~ex_kill & ex_fault;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pabort <= 1'b0;
         ifar   <= '0;
         ifsr   <= '0;
      end else begin
         pabort <= take;
         if (take) begin
            ifar <= {ex_unit, {OFS_W{1'b0}}};
            ifsr <= FSR_PARITY;
         end
      end
   end
endmodule

// File: rtl/ifetch_parity_guard.sv
module ifetch_parity_guard
   import ifpg_pkg::*;
#(
   parameter int               ADDR_W     = 12,
   parameter int               DEPTH      = 16,
   parameter int               INSTR_W    = 32,
   parameter int               FSR_W      = 5,
   parameter logic [FSR_W-1:0] FSR_PARITY = 5'h1A,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int SLOTS = UNIT_W / INSTR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fill_en,
   input  logic [IDX_W-1:0]        fill_idx,
   input  logic [UNIT_W-1:0]       fill_data,
   input  logic                    inj_en,
   input  logic [BSEL_W-1:0]       inj_byte,
   input  logic                    fetch_en,
   input  logic [ADDR_W-1:0]       fetch_addr,
   output logic                    rd_valid,
   output logic [ADDR_W-1:0]       rd_addr,
   output logic [UNIT_W-1:0]       rd_data,
   output logic [SLOTS-1:0]        rd_fault,
   input  logic                    ex_valid,
   input  logic                    ex_kill,
   input  logic                    ex_fault,
   input  logic [ADDR_W-OFS_W-1:0] ex_unit,
   output logic                    pabort,
   output logic [ADDR_W-1:0]       ifar,
   output logic [FSR_W-1:0]        ifsr
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (INSTR_W < 8 || (UNIT_W % INSTR_W) != 0) begin : g_bad_instr
      $error("INSTR_W must divide the fetch unit width");
   end
   if (ADDR_W < IDX_W + OFS_W + 1) begin : g_bad_addr
      $error("ADDR_W too small for DEPTH");
   end
   if (FSR_PARITY == '0) begin : g_bad_code
      $error("FSR_PARITY must differ from the reset value");
   end

   par_vec_t fill_par;
   par_vec_t inj_mask;
   par_vec_t wr_par;
   par_vec_t rd_par;

   ifpg_par_gen #(.NBYTES(UNIT_BYTES)) u_fill_par (
      .data (fill_data),
      .par  (fill_par)
   );

   always_comb begin
      inj_mask = '0;
      if (inj_en) inj_mask[inj_byte] = 1'b1;
   end

   assign wr_par = fill_par ^ inj_mask;

   ifpg_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (fill_en),
      .wr_idx    (fill_idx),
      .wr_data   (fill_data),
      .wr_par    (wr_par),
      .rd_en     (fetch_en),
      .rd_addr_i (fetch_addr),
      .rd_valid  (rd_valid),
      .rd_addr_o (rd_addr),
      .rd_data   (rd_data),
      .rd_par    (rd_par)
   );

   ifpg_check #(.SLOTS(SLOTS)) u_check (
      .valid      (rd_valid),
      .data       (rd_data),
      .par_stored (rd_par),
      .fault      (rd_fault)
   );

   ifpg_fault_cap #(.ADDR_W(ADDR_W), .FSR_W(FSR_W), .FSR_PARITY(FSR_PARITY)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .ex_valid (ex_valid),
      .ex_kill  (ex_kill),
      .ex_fault (ex_fault),
      .ex_unit  (ex_unit),
      .pabort   (pabort),
      .ifar     (ifar),
      .ifsr     (ifsr)
   );
endmodule

// File: rtl/ifetch_parity_guard_chk.sv
module ifetch_parity_guard_chk
   import ifpg_pkg::*;
#(
   parameter int               ADDR_W     = 12,
   parameter int               SLOTS      = 2,
   parameter int               FSR_W      = 5,
   parameter logic [FSR_W-1:0] FSR_PARITY = 5'h1A
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    fetch_en,
   input logic                    rd_valid,
   input logic [ADDR_W-1:0]       rd_addr,
   input logic [SLOTS-1:0]        rd_fault,
   input logic                    ex_valid,
   input logic                    ex_kill,
   input logic                    ex_fault,
   input logic [ADDR_W-OFS_W-1:0] ex_unit,
   input logic                    pabort,
   input logic [ADDR_W-1:0]       ifar,
   input logic [FSR_W-1:0]        ifsr
);
   // R5
   rd_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_en |=> rd_valid);

   // R5
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_en |=> !rd_valid);

   // R5
   rd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_addr[OFS_W-1:0] == '0));

   // R4
   first_slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fault >> 1) == '0);

   // R6
   abort_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && !ex_kill && ex_fault) |=>
         (pabort && ifsr == FSR_PARITY && ifar == {$past(ex_unit), {OFS_W{1'b0}}}));

   // R7
   no_abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_valid && !ex_kill && ex_fault) |=> (!pabort && $stable(ifar) && $stable(ifsr)));

   // R6
   ifar_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ifar[OFS_W-1:0] == '0);
endmodule

bind ifetch_parity_guard ifetch_parity_guard_chk #(
   .ADDR_W     (ADDR_W),
   .SLOTS      (SLOTS),
   .FSR_W      (FSR_W),
   .FSR_PARITY (FSR_PARITY)
) u_chk (.*);

// File: tb/tb_ifetch_parity_guard.sv
module tb_ifetch_parity_guard;
   localparam int ADDR_W = 12;
   localparam int DEPTH  = 16;
   localparam int IDX_W  = 4;
   localparam int SLOTS  = 2;
   localparam int FSR_W  = 5;
   localparam logic [4:0] CODE = 5'h1A;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fill_en = 1'b0;
   logic [IDX_W-1:0]  fill_idx = '0;
   logic [63:0]       fill_data = '0;
   logic              inj_en = 1'b0;
   logic [2:0]        inj_byte = '0;
   logic              fetch_en = 1'b0;
   logic [ADDR_W-1:0] fetch_addr = '0;
   logic              rd_valid;
   logic [ADDR_W-1:0] rd_addr;
   logic [63:0]       rd_data;
   logic [SLOTS-1:0]  rd_fault;
   logic              ex_valid = 1'b0;
   logic              ex_kill = 1'b0;
   logic              ex_fault = 1'b0;
   logic [ADDR_W-4:0] ex_unit = '0;
   logic              pabort;
   logic [ADDR_W-1:0] ifar;
   logic [FSR_W-1:0]  ifsr;

   int checks = 0;
   int errors = 0;
   logic [ADDR_W-1:0] exp_ifar = '0;
   logic [FSR_W-1:0]  exp_ifsr = '0;

   always #4 clk = ~clk;

   ifetch_parity_guard dut (.*);

   function automatic logic [63:0] pat(input int i);
      logic [63:0] v;
      for (int k = 0; k < 8; k++) v[8*k +: 8] = 8'((i * 37 + k * 53 + 11) & 255);
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_fill(input int idx, input logic [63:0] d, input bit inj, input int b);
      @(negedge clk);
      fill_en = 1'b1; fill_idx = IDX_W'(idx); fill_data = d;
      inj_en = inj; inj_byte = 3'(b);
      @(negedge clk);
      fill_en = 1'b0; inj_en = 1'b0;
   endtask

   task automatic do_fetch(input logic [ADDR_W-1:0] a, input logic [63:0] d,
                           input logic [SLOTS-1:0] f, input string req);
      @(negedge clk);
      fetch_en = 1'b1; fetch_addr = a;
      @(negedge clk);
      fetch_en = 1'b0;
      chk(rd_valid == 1'b1, "R5 valid", 64'(rd_valid), 64'd1);
      chk(rd_addr == {a[ADDR_W-1:3], 3'b000}, "R5 addr", 64'(rd_addr), 64'({a[ADDR_W-1:3], 3'b000}));
      chk(rd_data == d, req, rd_data, d);
      chk(rd_fault == f, {req, " R4 fault"}, 64'(rd_fault), 64'(f));
      @(negedge clk);
      chk(rd_valid == 1'b0, "R5 idle", 64'(rd_valid), 64'd0);
   endtask

   task automatic do_exec(input bit v, input bit k, input bit f, input logic [ADDR_W-4:0] u, input string req);
      bit take;
      take = v && !k && f;
      @(negedge clk);
      ex_valid = v; ex_kill = k; ex_fault = f; ex_unit = u;
      @(negedge clk);
      ex_valid = 1'b0; ex_kill = 1'b0; ex_fault = 1'b0;
      if (take) begin
         exp_ifar = {u, 3'b000};
         exp_ifsr = CODE;
      end
      chk(pabort == take, {req, " pabort"}, 64'(pabort), 64'(take));
      chk(ifar == exp_ifar, {req, " ifar"}, 64'(ifar), 64'(exp_ifar));
      chk(ifsr == exp_ifsr, {req, " ifsr"}, 64'(ifsr), 64'(exp_ifsr));
      @(negedge clk);
      chk(pabort == 1'b0, {req, " pulse end"}, 64'(pabort), 64'd0);
   endtask

   function automatic logic [ADDR_W-1:0] mk_addr(input int i, input int b);
      return ADDR_W'((((i * 7 + b) % 32) << 7) | (i << 3) | b);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(pabort == 1'b0 && rd_valid == 1'b0, "R8 outputs", 64'({pabort, rd_valid}), 64'd0);
      chk(ifar == '0 && ifsr == '0, "R8 regs", 64'({ifar, ifsr}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 fill every entry, fetch every entry at varied offsets
      for (int i = 0; i < DEPTH; i++) do_fill(i, pat(i), 1'b0, 0);
      for (int i = 0; i < DEPTH; i++) do_fetch(mk_addr(i, i % 8), pat(i), '0, "R1 clean");

      // R3 every byte position, R2 refill clears it
      for (int i = 0; i < DEPTH; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic [63:0] d;
            d = pat(i) ^ 64'(b * 8'h5B);
            do_fill(i, d, 1'b1, b);
            do_fetch(mk_addr(i, b), d, 2'b01, "R3 inject");
            do_fill(i, d, 1'b0, 0);
            do_fetch(mk_addr(i, 7 - b), d, 2'b00, "R2 refill");
         end
      end

      // R6 / R7 execute-side sweep over all control combinations
      for (int c = 0; c < 8; c++) begin
         do_exec(c[2], c[1], c[0], 9'((c * 71 + 5) % 512), "R6_R7 combo");
      end
      do_exec(1'b1, 1'b0, 1'b1, 9'h1FF, "R6 max unit");
      do_exec(1'b1, 1'b1, 1'b1, 9'h055, "R7 killed");
      do_exec(1'b1, 1'b0, 1'b0, 9'h0AA, "R7 no fault");
      do_exec(1'b0, 1'b0, 1'b1, 9'h123, "R7 not valid");
      do_exec(1'b1, 1'b0, 1'b1, 9'h000, "R6 zero unit");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule